// File: doc/BRIEF.md
# Bus Slave Arbiter with Burst and Slot Limits

This block decides which of up to eight bus masters owns a single slave port. Every master raises a request line and the block answers with a registered one-hot grant. Two policies are available: a rotating search that starts just after the master served most recently, or a fixed scheme where each master carries a 2-bit priority level. The policy and all other settings come from static configuration inputs.

Once a master is granted it keeps the slave for its whole burst, and the arbiter only reconsiders at a beat boundary. A master gives up ownership on its final beat or when it drops its request. A forced break can also end ownership: either its undefined-length burst has reached the per-master beat cap, or it has held the slave longer than the per-slave slot length. When nobody is requesting, a parking policy decides which master, if any, sees a grant while no transfer is in progress.

Top module: `bus_slot_arbiter`

## Requirements
- R1: After reset `grant_o` is zero and `hold_o` is low. `grant_o` is always zero or one-hot. A request sampled on a clock edge while no master holds the slave shows up as a grant, with `hold_o` high, right after that edge.
- R2: With `arb_fixed_i` = 0 the winner is the first requesting master found by searching upward from the index after the last granted master, wrapping around. Right after reset master 0 counts as the last granted.
- R3: With `arb_fixed_i` = 1 the requester with the largest priority `prio_i[2i+1:2i]` wins, and equal priorities go to the lowest index.
- R4: While a master holds the slave and keeps requesting, its grant stays unchanged until it signals a beat (`beat_i`) together with `last_i`, or until a forced break happens.
- R5: If the holding master drops its request, the slave is released at the next clock edge.
- R6: The burst cap `blen_i[3i+2:3i]` limits undefined-length bursts. Code 0 means unlimited, 1 means one beat, 2 means four beats, 3 means eight beats, 4 means sixteen beats, and codes 5 to 7 mean unlimited. The beat that reaches the cap is a forced break.
- R7: When `slot_max_i` is nonzero and the holding master has held the slave for at least `slot_max_i` cycles, its next beat is a forced break. A value of 0 disables this timeout.
- R8: At any release point the holding master can be granted again with no gap if it still requests and wins the arbitration.
- R9: With `park_type_i` = 0 (or the unused code 3), no request and no holder give an all-zero grant.
- R10: With `park_type_i` = 1 the last granted master is shown granted while `hold_o` is low.
- R11: With `park_type_i` = 2 the master indexed by `park_idx_i` is shown granted while `hold_o` is low.
- R12: A parked master gets no ownership. Any request is arbitrated on every cycle and takes the slave on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| arb_fixed_i | input | 1 | 0 selects round-robin, 1 selects fixed priority |
| slot_max_i | input | SLOT_W | Slot length limit in cycles, 0 disables it |
| park_type_i | input | 2 | Parking: 0 none, 1 last granted, 2 fixed index |
| park_idx_i | input | IDX_W | Master parked under the fixed parking mode |
| prio_i | input | 2*N_MST | 2-bit priority of each master |
| blen_i | input | 3*N_MST | 3-bit burst cap code of each master |
| req_i | input | N_MST | Request of each master |
| beat_i | input | N_MST | Master moves a data beat this cycle |
| last_i | input | N_MST | The beat is the final one of the burst |
| grant_o | output | N_MST | Registered one-hot grant |
| hold_o | output | 1 | Granted master owns the slave for a transfer |

## Verification
The assertions assume that the configuration inputs change only while no master holds the slave. They also assume that a master drives `beat_i` and `last_i` only for beats it actually moves while granted. The stability check relies on a holding master keeping its request up for as long as it wants the slave. The directed stimulus changes policy, caps, slot length and parking only between scenarios, when the slave is released. It drives requests and beats on the falling edge, so every value is settled before the rising edge samples it.

// File: rtl/arb_pkg.sv
package arb_pkg;
    localparam int PRIO_W = 2;
    localparam int BLEN_W = 3;
    localparam int BCNT_W = 5;

    typedef enum logic [1:0] {
        PARK_NONE  = 2'd0,
        PARK_LAST  = 2'd1,
        PARK_FIXED = 2'd2,
        PARK_RSVD  = 2'd3
    } park_e;

    // beat cap of an undefined-length burst, 0 = no cap
    function automatic logic [BCNT_W-1:0] burst_cap(input logic [BLEN_W-1:0] code);
        case (code)
            3'd1:    burst_cap = 5'd1;
            3'd2:    burst_cap = 5'd4;
            3'd3:    burst_cap = 5'd8;
            3'd4:    burst_cap = 5'd16;
            default: burst_cap = 5'd0;
        endcase
    endfunction
endpackage

// File: rtl/arb_pick.sv
module arb_pick
    import arb_pkg::*;
#(
    parameter int N_MST = 8,
    parameter int IDX_W = 3
) (
    input  logic [N_MST-1:0]        req,
    input  logic [PRIO_W*N_MST-1:0] prio,
    input  logic                    fixed,
    input  logic [IDX_W-1:0]        ptr,
    output logic                    found,
    output logic [IDX_W-1:0]        idx
);
    logic              rr_f, fp_f;
    logic [IDX_W-1:0]  rr_i, fp_i;
    logic [PRIO_W-1:0] fp_p;

    // rotating search starting after ptr
    always_comb begin
        rr_f = 1'b0;
        rr_i = '0;
        for (int k = 1; k <= N_MST; k++) begin
            int j;
            j = (int'(ptr) + k) % N_MST;
            if (!rr_f && req[j]) begin
                rr_f = 1'b1;
                rr_i = IDX_W'(j);
            end
        end
    end

    // strict greater keeps the lowest index on ties
    always_comb begin
        fp_f = 1'b0;
        fp_i = '0;
        fp_p = '0;
        for (int i = 0; i < N_MST; i++) begin
            if (req[i] && (!fp_f || prio[i*PRIO_W +: PRIO_W] > fp_p)) begin
                fp_f = 1'b1;
                fp_i = IDX_W'(i);
                fp_p = prio[i*PRIO_W +: PRIO_W];
            end
        end
    end

    assign found = fixed ? fp_f : rr_f;
    assign idx   = fixed ? fp_i : rr_i;
endmodule

// File: rtl/arb_brk.sv
module arb_brk
    import arb_pkg::*;
#(
    parameter int N_MST  = 8,
    parameter int IDX_W  = 3,
    parameter int SLOT_W = 8
) (
    input  logic                    busy,
    input  logic [IDX_W-1:0]        own,
    input  logic [N_MST-1:0]        req,
    input  logic [N_MST-1:0]        beat,
    input  logic [N_MST-1:0]        last,
    input  logic [BLEN_W*N_MST-1:0] blen,
    input  logic [SLOT_W-1:0]       slot_max,
    input  logic [SLOT_W-1:0]       scnt,
    input  logic [BCNT_W-1:0]       bcnt,
    output logic                    own_beat,
    output logic                    release_o
);
    logic [BCNT_W-1:0] cap;
    logic              cap_hit, slot_out;

    assign cap       = burst_cap(blen[own*BLEN_W +: BLEN_W]);
    assign cap_hit   = (cap != '0) && ({1'b0, bcnt} + 6'd1 == {1'b0, cap});
    assign slot_out  = (slot_max != '0) && (scnt >= slot_max);
    assign own_beat  = busy && beat[own];
    assign release_o = busy && (!req[own] ||
                       (own_beat && (last[own] || cap_hit || slot_out)));
endmodule

// File: rtl/bus_slot_arbiter.sv
module bus_slot_arbiter
    import arb_pkg::*;
#(
    parameter int N_MST  = 8,
    parameter int SLOT_W = 8,
    localparam int IDX_W = (N_MST > 1) ? $clog2(N_MST) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    arb_fixed_i,
    input  logic [SLOT_W-1:0]       slot_max_i,
    input  logic [1:0]              park_type_i,
    input  logic [IDX_W-1:0]        park_idx_i,
    input  logic [PRIO_W*N_MST-1:0] prio_i,
    input  logic [BLEN_W*N_MST-1:0] blen_i,
    input  logic [N_MST-1:0]        req_i,
    input  logic [N_MST-1:0]        beat_i,
    input  logic [N_MST-1:0]        last_i,
    output logic [N_MST-1:0]        grant_o,
    output logic                    hold_o
);
    typedef struct packed {
        logic [N_MST-1:0]  gnt;
        logic              busy;
        logic [IDX_W-1:0]  cur;   // current or most recent owner
        logic [SLOT_W-1:0] scnt;
        logic [BCNT_W-1:0] bcnt;
    } st_t;

    st_t s_d, s_q;

    logic             pick_f;
    logic [IDX_W-1:0] pick_i;
    logic             own_beat, rel;

    arb_pick #(.N_MST(N_MST), .IDX_W(IDX_W)) u_pick (
        .req   (req_i),
        .prio  (prio_i),
        .fixed (arb_fixed_i),
        .ptr   (s_q.cur),
        .found (pick_f),
        .idx   (pick_i)
    );

    arb_brk #(.N_MST(N_MST), .IDX_W(IDX_W), .SLOT_W(SLOT_W)) u_brk (
        .busy      (s_q.busy),
        .own       (s_q.cur),
        .req       (req_i),
        .beat      (beat_i),
        .last      (last_i),
        .blen      (blen_i),
        .slot_max  (slot_max_i),
        .scnt      (s_q.scnt),
        .bcnt      (s_q.bcnt),
        .own_beat  (own_beat),
        .release_o (rel)
    );

    always_comb begin
        s_d = s_q;
        if (s_q.busy && !rel) begin
            if (s_q.scnt != '1) s_d.scnt = s_q.scnt + 1'b1;
            if (own_beat)       s_d.bcnt = s_q.bcnt + 1'b1;
        end
        if (!s_q.busy || rel) begin
            s_d.gnt  = '0;
            s_d.scnt = '0;
            s_d.bcnt = '0;
            if (pick_f) begin
                s_d.busy        = 1'b1;
                s_d.cur         = pick_i;
                s_d.gnt[pick_i] = 1'b1;
            end else begin
                s_d.busy = 1'b0;
                case (park_e'(park_type_i))
                    PARK_LAST:  s_d.gnt[s_q.cur]    = 1'b1;
                    PARK_FIXED: s_d.gnt[park_idx_i] = 1'b1;
                    default:    s_d.gnt             = '0;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign grant_o = s_q.gnt;
    assign hold_o  = s_q.busy;
endmodule

// File: rtl/arb_chk.sv
module arb_chk #(
    parameter int N_MST = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       park_type_i,
    input logic [N_MST-1:0] req_i,
    input logic [N_MST-1:0] beat_i,
    input logic [N_MST-1:0] grant_o,
    input logic             hold_o
);
    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_o));                                                  // R1
    AST_NEW_GRANT_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        hold_o && !$past(hold_o) |-> |($past(req_i) & grant_o));             // R1
    AST_HOLD_HAS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        hold_o |-> $onehot(grant_o));                                        // R4
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        hold_o && |(req_i & grant_o) && !(|(beat_i & grant_o)) |=> $stable(grant_o)); // R4
    AST_PARK_NONE: assert property (@(posedge clk) disable iff (!rst_n)
        !hold_o && $past(park_type_i) == 2'd0 |-> grant_o == '0);           // R9
endmodule

bind bus_slot_arbiter arb_chk #(.N_MST(N_MST)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .park_type_i (park_type_i),
    .req_i       (req_i),
    .beat_i      (beat_i),
    .grant_o     (grant_o),
    .hold_o      (hold_o)
);

// File: tb/sim_bus_slot_arbiter.sv
`timescale 1ns/1ps
module sim_bus_slot_arbiter;
    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         arb_fixed_i = 1'b0;
    logic [7:0]   slot_max_i = 8'd0;
    logic [1:0]   park_type_i = 2'd0;
    logic [2:0]   park_idx_i = 3'd0;
    logic [2*N-1:0] prio_i = '0;
    logic [3*N-1:0] blen_i = '0;
    logic [N-1:0] req_i = '0, beat_i = '0, last_i = '0;
    logic [N-1:0] grant_o;
    logic         hold_o;

    int n_chk = 0;
    int n_err = 0;

    always #10 clk = ~clk;

    bus_slot_arbiter #(.N_MST(N), .SLOT_W(8)) u0 (
        .clk(clk), .rst_n(rst_n), .arb_fixed_i(arb_fixed_i),
        .slot_max_i(slot_max_i), .park_type_i(park_type_i),
        .park_idx_i(park_idx_i), .prio_i(prio_i), .blen_i(blen_i),
        .req_i(req_i), .beat_i(beat_i), .last_i(last_i),
        .grant_o(grant_o), .hold_o(hold_o)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s act=%b exp=%b", tag, act, exp);
        end
    endtask

    // drive at falling edge, let one rising edge pass, return at next falling edge
    task automatic step(input logic [7:0] rq, input logic [7:0] bt, input logic [7:0] ls);
        req_i = rq; beat_i = bt; last_i = ls;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 reset grant", grant_o, 8'h00);
        chk("R1 reset hold", {7'd0, hold_o}, 8'h01 & 8'h00);
    endtask

    task automatic t_round_robin();
        step(8'h24, 8'h00, 8'h00);
        chk("R2 first rr winner", grant_o, 8'h04);
        chk("R1 hold after grant", {7'd0, hold_o}, 8'h01);
        for (int i = 0; i < 3; i++) begin
            step(8'h24, 8'h04, 8'h00);
            chk("R4 hold mid burst (R7 slot off)", grant_o, 8'h04);
        end
        step(8'h24, 8'h04, 8'h04);
        chk("R2 rotate to 5", grant_o, 8'h20);
        step(8'h24, 8'h20, 8'h20);
        chk("R2 wrap to 2", grant_o, 8'h04);
        step(8'h04, 8'h04, 8'h04);
        chk("R8 regrant sole requester", grant_o, 8'h04);
        chk("R8 hold kept", {7'd0, hold_o}, 8'h01);
        step(8'h00, 8'h00, 8'h00);
        chk("R9 park none", grant_o, 8'h00);
    endtask

    task automatic t_fixed();
        arb_fixed_i = 1'b1;
        prio_i = '0;
        prio_i[2*1 +: 2] = 2'd1;
        prio_i[2*3 +: 2] = 2'd3;
        prio_i[2*6 +: 2] = 2'd3;
        step(8'h4A, 8'h00, 8'h00);
        chk("R3 tie lowest index", grant_o, 8'h08);
        step(8'h4A, 8'h08, 8'h08);
        chk("R3 highest keeps winning", grant_o, 8'h08);
        step(8'h42, 8'h08, 8'h08);
        chk("R3 next highest", grant_o, 8'h40);
        step(8'h02, 8'h40, 8'h40);
        chk("R3 low priority last", grant_o, 8'h02);
        step(8'h00, 8'h00, 8'h00);
        arb_fixed_i = 1'b0;
    endtask

    task automatic t_burst();
        blen_i[3*4 +: 3] = 3'd2;
        blen_i[3*7 +: 3] = 3'd1;
        step(8'h10, 8'h00, 8'h00);
        chk("R6 grant 4", grant_o, 8'h10);
        for (int i = 0; i < 3; i++) begin
            step(8'h90, 8'h10, 8'h00);
            chk("R6 below four-beat cap", grant_o, 8'h10);
        end
        step(8'h90, 8'h10, 8'h00);
        chk("R6 four-beat cap break", grant_o, 8'h80);
        step(8'h90, 8'h80, 8'h00);
        chk("R6 single-beat cap break", grant_o, 8'h10);
        step(8'h00, 8'h00, 8'h00);
        blen_i = '0;
    endtask

    task automatic t_slot();
        slot_max_i = 8'd3;
        step(8'h01, 8'h00, 8'h00);
        chk("R7 grant 0", grant_o, 8'h01);
        step(8'h03, 8'h01, 8'h00);
        chk("R7 early beat no break", grant_o, 8'h01);
        step(8'h03, 8'h00, 8'h00);
        chk("R7 slot running", grant_o, 8'h01);
        step(8'h03, 8'h00, 8'h00);
        chk("R7 slot expired no beat", grant_o, 8'h01);
        step(8'h03, 8'h01, 8'h00);
        chk("R7 break at beat", grant_o, 8'h02);
        step(8'h00, 8'h00, 8'h00);
        slot_max_i = 8'd0;
    endtask

    task automatic t_drop();
        step(8'h08, 8'h00, 8'h00);
        chk("R5 grant 3", grant_o, 8'h08);
        step(8'h00, 8'h00, 8'h00);
        chk("R5 release on drop", grant_o, 8'h00);
        chk("R5 hold low", {7'd0, hold_o}, 8'h00);
    endtask

    task automatic t_park();
        park_type_i = 2'd1;
        step(8'h20, 8'h00, 8'h00);
        step(8'h00, 8'h00, 8'h00);
        chk("R10 park last", grant_o, 8'h20);
        chk("R10 parked not held", {7'd0, hold_o}, 8'h00);
        park_type_i = 2'd2;
        park_idx_i = 3'd6;
        step(8'h00, 8'h00, 8'h00);
        chk("R11 park fixed", grant_o, 8'h40);
        step(8'h02, 8'h00, 8'h00);
        chk("R12 requester takes parked slave", grant_o, 8'h02);
        chk("R12 hold", {7'd0, hold_o}, 8'h01);
        step(8'h00, 8'h00, 8'h00);
        chk("R11 back to parked", grant_o, 8'h40);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_round_robin();
        t_fixed();
        t_burst();
        t_slot();
        t_drop();
        t_park();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog R1 act=hung exp=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
        $finish;
    end
endmodule